// File: doc/BRIEF.md
# Open-Drain Pin Pair Control Register

This block is a single memory-mapped control word for a pair of open-drain pins, a clock line and a data line. Software drives the I2C waveform on these pins one step at a time. The block stores the direction, output value and pull-up disable setting of each pin. It drives the pad tri-state enables, and it brings each pad input back through a synchronizer so that software can read it.

The pins are open-drain, so a pin only ever pulls its line low. To drive a pin low, software makes the pin an output with value low. To release the line, software makes the pin an input, and the external pull-up raises the line. Each pin has two write-enable bits in the same word, one for its direction and one for its value. A write therefore changes only the fields whose enable bit it sets. Software can move one line without first reading the register to preserve the other.

Each pin owns one 8-bit lane of the word. Lane 0 (bits 7:0) is the clock pin and lane 1 (bits 15:8) is the data pin. Inside a lane, the bits are:

- bit 0: direction write-enable
- bit 1: direction (1 = output)
- bit 2: value write-enable
- bit 3: output value
- bit 4: synchronized input (read-only)
- bit 5: pull-up disable

All other bits are zero on read.

Top module: `od_pin_pair_reg`

## Requirements
- R1: While reset is asserted and right after it, every pin is an input (pad_oe low), pad_out is low, and reg_rdata reads zero as long as the pad inputs are low.
- R2: A pin's direction (lane bit 1) changes on a write only when that lane's bit 0 is set in the same write word; otherwise it keeps its value.
- R3: A pin's output value (lane bit 3) changes on a write only when that lane's bit 2 is set in the same write word; otherwise it keeps its value.
- R4: The write-enable bits (lane bits 0 and 2), lane bits 6 and 7 and every bit above bit 15 always read as zero.
- R5: A pin's pull-up disable bit (lane bit 5) takes the written value on every write and reads back unchanged.
- R6: pad_oe of a pin equals its stored direction, and pad_out equals its stored value. The outputs change one clock edge after the write.
- R7: Lane bit 4 shows the pad input through two flip-flops. A change in the pad input is not yet visible after one rising edge and is visible after two.
- R8: A write that sets the enable bits of one lane only leaves the direction and value of the other pin unchanged.
- R9: When reg_wr is low, the value on reg_wdata has no effect on any stored field or pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data, including the write-enable bits |
| reg_rdata | output | 32 | Read data: stored fields and synchronized inputs |
| pad_oe | output | 2 | Output enable per pin (0 = clock, 1 = data) |
| pad_out | output | 2 | Output value per pin |
| pad_in | input | 2 | Raw pad input per pin |

## Verification
A wrong stored direction or value shows on pad_oe or pad_out, and in the read word, at the first sample after the offending clock edge. The bench sweeps every combination of write-enable bits, field values and pull-up bits on both lanes, and compares the results against a model of the masked update. A broken mask shows up after one write, and so does leakage between lanes. A synchronizer of the wrong depth shows up one cycle early or one cycle late at the input bit.

// File: rtl/odp_pkg.sv
package odp_pkg;
    localparam int LANE_W   = 8;
    localparam int F_DIR_WE = 0;
    localparam int F_DIR    = 1;
    localparam int F_VAL_WE = 2;
    localparam int F_VAL    = 3;
    localparam int F_IN     = 4;
    localparam int F_PU_DIS = 5;

    typedef struct packed {
        logic dir;
        logic val;
        logic pu_dis;
    } lane_reg_t;
endpackage

// File: rtl/odp_sync.sv
module odp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/odp_lane.sv
module odp_lane
    import odp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_dir_we,
    input  logic              wr_dir,
    input  logic              wr_val_we,
    input  logic              wr_val,
    input  logic              wr_pu_dis,
    input  logic              pad_in,
    output logic              pad_oe,
    output logic              pad_out,
    output logic [LANE_W-1:0] rd_lane
);
    lane_reg_t lane_d, lane_q;
    logic      in_sync;

    odp_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (in_sync)
    );

    always_comb begin
        lane_d = lane_q;
        if (wr_en) begin
            if (wr_dir_we) lane_d.dir = wr_dir;
            if (wr_val_we) lane_d.val = wr_val;
            lane_d.pu_dis = wr_pu_dis;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    always_comb begin
        rd_lane           = '0;
        rd_lane[F_DIR]    = lane_q.dir;
        rd_lane[F_VAL]    = lane_q.val;
        rd_lane[F_IN]     = in_sync;
        rd_lane[F_PU_DIS] = lane_q.pu_dis;
    end

    assign pad_oe  = lane_q.dir;
    assign pad_out = lane_q.val;
endmodule

// File: rtl/od_pin_pair_reg.sv
module od_pin_pair_reg
    import odp_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int PIN_COUNT   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic [PIN_COUNT-1:0] pad_oe,
    output logic [PIN_COUNT-1:0] pad_out,
    input  logic [PIN_COUNT-1:0] pad_in
);
    localparam int USED_W = PIN_COUNT * LANE_W;

    logic [USED_W-1:0] lanes_rd;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata;

    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_lane
        localparam int BASE = p * LANE_W;
        odp_lane #(.SYNC_STAGES(SYNC_STAGES)) i_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_wr),
            .wr_dir_we(reg_wdata[BASE+F_DIR_WE]),
            .wr_dir   (reg_wdata[BASE+F_DIR]),
            .wr_val_we(reg_wdata[BASE+F_VAL_WE]),
            .wr_val   (reg_wdata[BASE+F_VAL]),
            .wr_pu_dis(reg_wdata[BASE+F_PU_DIS]),
            .pad_in   (pad_in[p]),
            .pad_oe   (pad_oe[p]),
            .pad_out  (pad_out[p]),
            .rd_lane  (lanes_rd[BASE +: LANE_W])
        );
    end

    always_comb begin
        reg_rdata             = '0;
        reg_rdata[USED_W-1:0] = lanes_rd;
    end
endmodule

// File: rtl/odp_chk.sv
module odp_chk
    import odp_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int PIN_COUNT   = 2,
    parameter int SYNC_STAGES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [DATA_W-1:0]    reg_wdata,
    input logic [DATA_W-1:0]    reg_rdata,
    input logic [PIN_COUNT-1:0] pad_oe,
    input logic [PIN_COUNT-1:0] pad_out,
    input logic [PIN_COUNT-1:0] pad_in
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
        localparam int B = p * LANE_W;

        assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_wr && reg_wdata[B+F_DIR_WE]) |=> $stable(pad_oe[p]));

        assert_val_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_wr && reg_wdata[B+F_VAL_WE]) |=> $stable(pad_out[p]));

        assert_mask_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rdata[B+F_DIR_WE] == 1'b0) && (reg_rdata[B+F_VAL_WE] == 1'b0));

        assert_pu_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
            reg_wr |=> reg_rdata[B+F_PU_DIS] == $past(reg_wdata[B+F_PU_DIS]));

        assert_pad_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_oe[p] == reg_rdata[B+F_DIR]) && (pad_out[p] == reg_rdata[B+F_VAL]));

        if (SYNC_STAGES == 2) begin : g_sync
            assert_sync_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst == 3) |-> reg_rdata[B+F_IN] == $past(pad_in[p], 2));
        end
    end

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(reg_rdata[PIN_COUNT*LANE_W-1:0] & {PIN_COUNT{8'b1110_1111}}));
endmodule

bind od_pin_pair_reg odp_chk #(
    .DATA_W     (DATA_W),
    .PIN_COUNT  (PIN_COUNT),
    .SYNC_STAGES(SYNC_STAGES)
) i_odp_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out),
    .pad_in   (pad_in)
);

// File: tb/test_od_pin_pair_reg.sv
module test_od_pin_pair_reg;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  pad_oe, pad_out;
    logic [1:0]  pad_in = 2'b00;

    int n_checks = 0;
    int n_fail   = 0;
    logic [1:0] m_dir = '0, m_val = '0, m_pu = '0;

    od_pin_pair_reg i_od_pin_pair_reg (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pad_oe(pad_oe), .pad_out(pad_out), .pad_in(pad_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_word(input logic [1:0] pin_in);
        logic [31:0] w = '0;
        for (int p = 0; p < 2; p++) begin
            w[p*8+1] = m_dir[p];
            w[p*8+3] = m_val[p];
            w[p*8+4] = pin_in[p];
            w[p*8+5] = m_pu[p];
        end
        return w;
    endfunction

    task automatic check_all(input string req);
        check({req, " rdata"}, reg_rdata, expect_word(pad_in));
        check({req, " R6 pads"}, {30'd0, pad_oe}, {30'd0, m_dir});
        check({req, " R6 out"}, {30'd0, pad_out}, {30'd0, m_val});
    endtask

    task automatic do_write(input logic [31:0] w);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = w;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = ~w;
        for (int p = 0; p < 2; p++) begin
            if (w[p*8+0]) m_dir[p] = w[p*8+1];
            if (w[p*8+2]) m_val[p] = w[p*8+3];
            m_pu[p] = w[p*8+5];
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset");

        // R2 R3 R4 R5 R8: exhaustive sweep of the five writable bits per lane
        pad_in = 2'b10;
        repeat (3) @(negedge clk);
        for (int v = 0; v < 1024; v++) begin
            logic [31:0] w;
            w = '0;
            w[5:0]   = {v[4], 1'b0, v[3:0]};
            w[13:8]  = {v[9], 1'b0, v[8:5]};
            w[7:6]   = v[1:0];
            w[15:14] = v[3:2];
            w[31:16] = {v[9:0], v[5:0]};
            w[4]     = v[0];
            w[12]    = v[6];
            do_write(w);
            check_all("R2 R3 R4 R5 R8 sweep");
        end

        // R8: clock lane only, data lane untouched
        do_write(32'h0000_0B0B);
        do_write(32'h0000_000F);
        check({"R8 data lane kept"}, {30'd0, pad_oe[1], pad_out[1]}, 32'd3);
        check_all("R8 clock lane only");

        // R9: idle cycles with arbitrary wdata
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            reg_wr = 1'b0;
            reg_wdata = 32'hFFFF_FFFF ^ (32'h1357_9BDF << k);
            @(negedge clk);
            check_all("R9 idle write data ignored");
        end

        // R7: synchronizer latency, all transitions of both pins
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                logic [1:0] old_in;
                pad_in = a[1:0];
                repeat (3) @(negedge clk);
                old_in = pad_in;
                pad_in = b[1:0];
                @(negedge clk);
                check("R7 one edge", reg_rdata, expect_word(old_in));
                @(negedge clk);
                check("R7 two edges", reg_rdata, expect_word(b[1:0]));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule